// File: doc/BRIEF.md
# Factory Bad Block Scanner

This block builds the initial invalid-block table of a NAND array before any program or erase is allowed. After a start pulse it walks every block in ascending order. For each block it asks a lower page-read engine for the first spare-area byte of page 0 (column address just past the data area). If that byte is FFh it also asks for the same byte of page 1. A block is invalid when either byte differs from FFh or when the engine reports a read error. The verdict goes into a table with one bit per block, which the host can read through a lookup port.

The block reports a running count of invalid blocks and a done flag. It raises an anomaly flag when the count goes above the allowed limit, or when block 0 turns out invalid, since block 0 is guaranteed good at shipment. A read error from the engine marks the block bad and sets a sticky error flag. The interface to the engine is a single-cycle request carrying row and column, answered later by a single-cycle response with a data byte and an error bit.

Top module: `badblk_scanner`

## Requirements
- R1: A start pulse while idle clears the table, the count, done, anomaly and the error flag; busy is high from the next cycle until the last block is classified, after which busy is low and done is high.
- R2: Each read request is a one-cycle rd_req pulse with rd_row = block*PAGES_PER_BLOCK + page and rd_col = PAGE_BYTES (the first spare byte); blocks are requested in ascending order from 0 to NUM_BLOCKS-1, page 0 before page 1.
- R3: If the page 0 marker byte is not FFh the block is marked bad and no page 1 read is issued for it.
- R4: If the page 0 marker is FFh, page 1 is read; the block is bad if the page 1 marker is not FFh and good if both are FFh. Markers of pages 2 and above never affect the result.
- R5: A response with resp_err high marks the block bad whatever its data byte is (an error on page 0 skips the page 1 read) and sets err_flag, which stays high until the next start.
- R6: After a scan, tbl_bad for tbl_addr = b is 1 exactly when block b was classified bad, and bad_count equals the number of bad blocks.
- R7: anomaly is high after a scan exactly when bad_count exceeds MAX_BAD or block 0 was classified bad.
- R8: A start pulse while busy is ignored: the scan continues without restarting.
- R9: A resp_valid pulse while no read is outstanding is ignored: table, count, flags and done keep their values.
- R10: After reset busy, done, rd_req, bad_count, anomaly and err_flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted only when idle |
| rd_req | output | 1 | One-cycle read request to the page-read engine |
| rd_row | output | log2(NUM_BLOCKS)+log2(PAGES_PER_BLOCK) | Row address of the request |
| rd_col | output | log2(PAGE_BYTES+SPARE_BYTES) | Column address of the request |
| resp_valid | input | 1 | One-cycle response strobe from the engine |
| resp_data | input | 8 | Byte returned with the response |
| resp_err | input | 1 | Read error reported with the response |
| tbl_addr | input | log2(NUM_BLOCKS) | Block index for table lookup |
| tbl_bad | output | 1 | Table bit of the addressed block (1 = bad) |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Scan finished |
| bad_count | output | log2(NUM_BLOCKS+1) | Number of bad blocks found |
| anomaly | output | 1 | Count above MAX_BAD or block 0 bad |
| err_flag | output | 1 | Sticky read-error flag |

## Verification
A read error and an FFh data byte can arrive in the same response, so the error path and the marker comparison fall in one cycle; the bench programs rows with resp_err high and data FFh and judges that the block is counted bad, that no page 1 request follows and that err_flag is set. Likewise, classification of the last block and the threshold test of the count coincide with the anomaly update, provoked by scans with exactly MAX_BAD and MAX_BAD+1 bad blocks including the final one. The bench sweeps category patterns over every block of a 16-block configuration and computes the expected count, table, read count and flags arithmetically.

// File: rtl/bbs_pkg.sv
package bbs_pkg;

  // Value a good block carries in its marker byte
  localparam logic [7:0] MARK_GOOD = 8'hFF;

  typedef enum logic [2:0] {
    S_IDLE  = 3'd0,
    S_ISS0  = 3'd1,
    S_WAIT0 = 3'd2,
    S_ISS1  = 3'd3,
    S_WAIT1 = 3'd4
  } scan_state_e;

endpackage

// File: rtl/bbs_ctrl.sv
// Scan sequencer: walks the blocks, issues marker reads, classifies.
// PAGES_PER_BLOCK must be a power of two (row = {block, page}).
module bbs_ctrl
  import bbs_pkg::*;
#(
  parameter int NUM_BLOCKS      = 1024,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int PAGE_BYTES      = 2048,
  parameter int SPARE_BYTES     = 64
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  output logic                                   rd_req,
  output logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLOCK)-1:0] rd_row,
  output logic [$clog2(PAGE_BYTES+SPARE_BYTES)-1:0] rd_col,
  input  logic                                   resp_valid,
  input  logic [7:0]                             resp_data,
  input  logic                                   resp_err,
  output logic                                   busy,
  output logic                                   clr,
  output logic                                   mark_vld,
  output logic [$clog2(NUM_BLOCKS)-1:0]          mark_idx,
  output logic                                   err_set,
  output logic                                   fin
);

  localparam int BLK_W = $clog2(NUM_BLOCKS);
  localparam int PG_W  = $clog2(PAGES_PER_BLOCK);
  localparam int COL_W = $clog2(PAGE_BYTES + SPARE_BYTES);
  localparam logic [BLK_W-1:0] LAST_BLK = BLK_W'(NUM_BLOCKS - 1);
  localparam logic [COL_W-1:0] MARK_COL = COL_W'(PAGE_BYTES);

  scan_state_e      state_q, state_d;
  logic [BLK_W-1:0] blk_q, blk_d;
  logic             blk_en;
  logic             blk_done;
  logic             blk_bad;
  logic             resp_bad;

  // A response is bad on an error or any marker value other than FFh
  assign resp_bad = resp_err | (resp_data != MARK_GOOD);

  always_comb begin
    state_d  = state_q;
    blk_d    = blk_q;
    blk_en   = 1'b0;
    clr      = 1'b0;
    err_set  = 1'b0;
    blk_done = 1'b0;
    blk_bad  = 1'b0;
    fin      = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start) begin
          clr     = 1'b1;
          blk_d   = '0;
          blk_en  = 1'b1;
          state_d = S_ISS0;
        end
      end
      S_ISS0: state_d = S_WAIT0;
      S_WAIT0: begin
        if (resp_valid) begin
          err_set = resp_err;
          if (resp_bad) begin
            blk_done = 1'b1;
            blk_bad  = 1'b1;
          end else begin
            state_d = S_ISS1;
          end
        end
      end
      S_ISS1: state_d = S_WAIT1;
      S_WAIT1: begin
        if (resp_valid) begin
          err_set  = resp_err;
          blk_done = 1'b1;
          blk_bad  = resp_bad;
        end
      end
      default: state_d = S_IDLE;
    endcase

    if (blk_done) begin
      if (blk_q == LAST_BLK) begin
        fin     = 1'b1;
        state_d = S_IDLE;
      end else begin
        blk_d   = blk_q + 1'b1;
        blk_en  = 1'b1;
        state_d = S_ISS0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= '0;
    end else if (blk_en) begin
      blk_q <= blk_d;
    end
  end

  assign mark_vld = blk_done & blk_bad;
  assign mark_idx = blk_q;
  assign busy     = (state_q != S_IDLE);
  assign rd_req   = (state_q == S_ISS0) || (state_q == S_ISS1);
  assign rd_row   = {blk_q, PG_W'(state_q == S_ISS1)};
  assign rd_col   = MARK_COL;

endmodule

// File: rtl/bbs_table.sv
// One flag bit per block, cleared in one cycle, set by the sequencer.
module bbs_table #(
  parameter int NUM_BLOCKS = 1024
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          mark_vld,
  input  logic [$clog2(NUM_BLOCKS)-1:0] mark_idx,
  input  logic [$clog2(NUM_BLOCKS)-1:0] rd_idx,
  output logic                          rd_bad
);

  localparam int BLK_W = $clog2(NUM_BLOCKS);

  logic [NUM_BLOCKS-1:0] bad_q;

  for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_bit
    logic set_i;
    assign set_i = mark_vld && (mark_idx == BLK_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bad_q[i] <= 1'b0;
      end else if (clr) begin
        bad_q[i] <= 1'b0;
      end else if (set_i) begin
        bad_q[i] <= 1'b1;
      end
    end
  end

  assign rd_bad = bad_q[rd_idx];

endmodule

// File: rtl/bbs_tally.sv
// Bad-block counter, anomaly detection, sticky error and done flags.
module bbs_tally #(
  parameter int NUM_BLOCKS = 1024,
  parameter int MAX_BAD    = 20
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            mark_vld,
  input  logic [$clog2(NUM_BLOCKS)-1:0]   mark_idx,
  input  logic                            err_set,
  input  logic                            fin,
  output logic [$clog2(NUM_BLOCKS+1)-1:0] bad_count,
  output logic                            anomaly,
  output logic                            err_flag,
  output logic                            done
);

  localparam int CNT_W = $clog2(NUM_BLOCKS + 1);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(MAX_BAD);

  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             anom_q, anom_hit;
  logic             err_q;
  logic             done_q;

  assign cnt_inc  = cnt_q + 1'b1;
  assign anom_hit = mark_vld && ((cnt_inc > LIMIT) || (mark_idx == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (mark_vld) begin
      cnt_q <= cnt_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      anom_q <= 1'b0;
    end else if (clr) begin
      anom_q <= 1'b0;
    end else if (anom_hit) begin
      anom_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else if (clr) begin
      err_q <= 1'b0;
    end else if (err_set) begin
      err_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b0;
    end else if (clr) begin
      done_q <= 1'b0;
    end else if (fin) begin
      done_q <= 1'b1;
    end
  end

  assign bad_count = cnt_q;
  assign anomaly   = anom_q;
  assign err_flag  = err_q;
  assign done      = done_q;

endmodule

// File: rtl/badblk_scanner.sv
module badblk_scanner #(
  parameter int NUM_BLOCKS      = 1024,
  parameter int PAGES_PER_BLOCK = 64,
  parameter int PAGE_BYTES      = 2048,
  parameter int SPARE_BYTES     = 64,
  parameter int MAX_BAD         = 20
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   start,
  output logic                                   rd_req,
  output logic [$clog2(NUM_BLOCKS)+$clog2(PAGES_PER_BLOCK)-1:0] rd_row,
  output logic [$clog2(PAGE_BYTES+SPARE_BYTES)-1:0] rd_col,
  input  logic                                   resp_valid,
  input  logic [7:0]                             resp_data,
  input  logic                                   resp_err,
  input  logic [$clog2(NUM_BLOCKS)-1:0]          tbl_addr,
  output logic                                   tbl_bad,
  output logic                                   busy,
  output logic                                   done,
  output logic [$clog2(NUM_BLOCKS+1)-1:0]        bad_count,
  output logic                                   anomaly,
  output logic                                   err_flag
);

  localparam int BLK_W = $clog2(NUM_BLOCKS);

  logic             clr;
  logic             mark_vld;
  logic [BLK_W-1:0] mark_idx;
  logic             err_set;
  logic             fin;

  bbs_ctrl #(
    .NUM_BLOCKS      (NUM_BLOCKS),
    .PAGES_PER_BLOCK (PAGES_PER_BLOCK),
    .PAGE_BYTES      (PAGE_BYTES),
    .SPARE_BYTES     (SPARE_BYTES)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .rd_req     (rd_req),
    .rd_row     (rd_row),
    .rd_col     (rd_col),
    .resp_valid (resp_valid),
    .resp_data  (resp_data),
    .resp_err   (resp_err),
    .busy       (busy),
    .clr        (clr),
    .mark_vld   (mark_vld),
    .mark_idx   (mark_idx),
    .err_set    (err_set),
    .fin        (fin)
  );

  bbs_table #(
    .NUM_BLOCKS (NUM_BLOCKS)
  ) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .mark_vld (mark_vld),
    .mark_idx (mark_idx),
    .rd_idx   (tbl_addr),
    .rd_bad   (tbl_bad)
  );

  bbs_tally #(
    .NUM_BLOCKS (NUM_BLOCKS),
    .MAX_BAD    (MAX_BAD)
  ) u_tally (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .mark_vld  (mark_vld),
    .mark_idx  (mark_idx),
    .err_set   (err_set),
    .fin       (fin),
    .bad_count (bad_count),
    .anomaly   (anomaly),
    .err_flag  (err_flag),
    .done      (done)
  );

endmodule

// File: rtl/badblk_scanner_chk.sv
module badblk_scanner_chk #(
  parameter int COL_W      = 12,
  parameter int CNT_W      = 11,
  parameter int PAGE_BYTES = 2048,
  parameter int MAX_BAD    = 20
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             rd_req,
  input logic [COL_W-1:0] rd_col,
  input logic             busy,
  input logic             done,
  input logic [CNT_W-1:0] bad_count,
  input logic             anomaly,
  input logic             err_flag
);

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);                                             // R2
  AST_REQ_SPARE_COL: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_col == COL_W'(PAGE_BYTES)));                      // R2
  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);                                              // R2
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));                                                // R1
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);                                      // R1
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_count != $past(bad_count)) |->
      ((bad_count == CNT_W'($past(bad_count) + 1'b1)) || (bad_count == '0))); // R6
  AST_ANOMALY_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (bad_count > CNT_W'(MAX_BAD)) |-> anomaly);                      // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (err_flag && !start) |=> err_flag);                              // R5

endmodule

bind badblk_scanner badblk_scanner_chk #(
  .COL_W      ($clog2(PAGE_BYTES + SPARE_BYTES)),
  .CNT_W      ($clog2(NUM_BLOCKS + 1)),
  .PAGE_BYTES (PAGE_BYTES),
  .MAX_BAD    (MAX_BAD)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .rd_req    (rd_req),
  .rd_col    (rd_col),
  .busy      (busy),
  .done      (done),
  .bad_count (bad_count),
  .anomaly   (anomaly),
  .err_flag  (err_flag)
);

// File: tb/badblk_scanner_test.sv
module badblk_scanner_test;

  localparam int NB    = 16;
  localparam int PG    = 4;
  localparam int PB    = 2048;
  localparam int SB    = 64;
  localparam int MB    = 3;
  localparam int BW    = 4;
  localparam int PW    = 2;
  localparam int RW    = BW + PW;
  localparam int CW    = 12;
  localparam int KW    = 5;
  localparam int NROWS = NB * PG;

  logic          clk;
  logic          rst_n;
  logic          start;
  logic          rd_req;
  logic [RW-1:0] rd_row;
  logic [CW-1:0] rd_col;
  logic          resp_valid;
  logic [7:0]    resp_data;
  logic          resp_err;
  logic [BW-1:0] tbl_addr;
  logic          tbl_bad;
  logic          busy;
  logic          done;
  logic [KW-1:0] bad_count;
  logic          anomaly;
  logic          err_flag;

  badblk_scanner #(
    .NUM_BLOCKS(NB), .PAGES_PER_BLOCK(PG), .PAGE_BYTES(PB),
    .SPARE_BYTES(SB), .MAX_BAD(MB)
  ) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .rd_req(rd_req),
    .rd_row(rd_row), .rd_col(rd_col), .resp_valid(resp_valid),
    .resp_data(resp_data), .resp_err(resp_err), .tbl_addr(tbl_addr),
    .tbl_bad(tbl_bad), .busy(busy), .done(done), .bad_count(bad_count),
    .anomaly(anomaly), .err_flag(err_flag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks   = 0;
  int failures = 0;

  logic [7:0] mk [NROWS];
  logic       er [NROWS];

  int lat      = 1;
  int reads    = 0;
  int seq_err  = 0;
  int exp_blk  = 0;
  bit exp_p1   = 0;
  bit spur_req = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Page-read engine model: answers each request lat cycles later
  initial begin
    int cnt = 0;
    int row = 0;
    resp_valid = 1'b0;
    resp_data  = 8'h00;
    resp_err   = 1'b0;
    forever begin
      @(negedge clk);
      resp_valid = 1'b0;
      resp_err   = 1'b0;
      resp_data  = 8'h00;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          resp_valid = 1'b1;
          resp_data  = mk[row];
          resp_err   = er[row];
        end
      end else if (rd_req) begin
        row = int'(rd_row);
        reads++;
        // R2: expected row in ascending block order, page 0 then page 1
        if (row != exp_blk * PG + (exp_p1 ? 1 : 0) || rd_col != CW'(PB))
          seq_err++;
        if (!exp_p1) begin
          if (er[row] || mk[row] != 8'hFF) exp_blk++;
          else exp_p1 = 1'b1;
        end else begin
          exp_blk++;
          exp_p1 = 1'b0;
        end
        cnt = lat;
      end else if (spur_req) begin
        resp_valid = 1'b1;
        resp_data  = 8'h00;
        resp_err   = 1'b1;
        spur_req   = 1'b0;
      end
    end
  end

  // Category per block: 0 good, 1 page0 bad value, 2 page1 bad value,
  // 3 page0 error, 4 page1 error, 5 page0 error with FFh data,
  // 6 page2 bad value (irrelevant)
  task automatic set_cat(input int b, input int c);
    int r0 = b * PG;
    logic [7:0] v = 8'((b * 37 + c * 11) & 8'hFE);
    for (int p = 0; p < PG; p++) begin
      mk[r0 + p] = 8'hFF;
      er[r0 + p] = 1'b0;
    end
    case (c)
      1: mk[r0]     = v;
      2: mk[r0 + 1] = v;
      3: begin er[r0] = 1'b1; mk[r0] = v; end
      4: er[r0 + 1] = 1'b1;
      5: er[r0]     = 1'b1;
      6: mk[r0 + 2] = v;
      default: ;
    endcase
  endtask

  task automatic run_scan(input int latency, input bit mid_start, input string tag);
    int wd = 0;
    lat     = latency;
    reads   = 0;
    seq_err = 0;
    exp_blk = 0;
    exp_p1  = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1 && done == 1'b0 && bad_count == '0, {tag, " R1 busy after start"},
        int'({busy, done}), 2);
    while (busy && wd < 4000) begin
      @(negedge clk);
      wd++;
      if (mid_start && wd == 9) start = 1'b1;
      if (mid_start && wd == 10) start = 1'b0;
    end
  endtask

  task automatic verify(input string tag);
    int  ebad  = 0;
    int  ereads = 0;
    bit  eerr  = 0;
    bit  b0bad = 0;
    bit  tbl_ok = 1;
    for (int b = 0; b < NB; b++) begin
      int  r0 = b * PG;
      bit  g0 = !er[r0] && mk[r0] == 8'hFF;
      bit  bb = !g0 || er[r0 + 1] || mk[r0 + 1] != 8'hFF;
      ereads += g0 ? 2 : 1;
      if (er[r0] || (g0 && er[r0 + 1])) eerr = 1;
      if (bb) ebad++;
      if (b == 0) b0bad = bb;
      tbl_addr = BW'(b);
      #1;
      if (tbl_bad != bb) begin
        tbl_ok = 0;
        chk(0, {tag, " R6 table bit"}, int'(tbl_bad), int'(bb));
      end
    end
    chk(tbl_ok, {tag, " R6 table all blocks"}, 0, 0);
    chk(done == 1'b1 && busy == 1'b0, {tag, " R1 done/busy"}, int'({done, busy}), 2);
    chk(int'(bad_count) == ebad, {tag, " R6 count"}, int'(bad_count), ebad);
    chk(anomaly == ((ebad > MB) || b0bad), {tag, " R7 anomaly"}, int'(anomaly),
        int'((ebad > MB) || b0bad));
    chk(err_flag == eerr, {tag, " R5 err_flag"}, int'(err_flag), int'(eerr));
    chk(reads == ereads, {tag, " R3 R4 read count"}, reads, ereads);
    chk(seq_err == 0, {tag, " R2 request order/address"}, seq_err, 0);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    rst_n    = 1'b0;
    start    = 1'b0;
    tbl_addr = '0;
    for (int b = 0; b < NB; b++) set_cat(b, 0);
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !rd_req && bad_count == '0 && !anomaly && !err_flag,
        "R10 reset state", int'({busy, done, rd_req, anomaly, err_flag}), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !rd_req, "R10 idle after release", int'({busy, rd_req}), 0);

    // All blocks good
    run_scan(1, 0, "all-good");
    verify("all-good");

    // R9 spurious response while idle
    spur_req = 1'b1;
    repeat (4) @(negedge clk);
    chk(done && !busy && bad_count == '0 && !err_flag && !anomaly,
        "R9 stray response ignored", int'({done, busy, err_flag, anomaly}), 8);

    // Near-exhaustive category sweep (R3 R4 R5)
    for (int k = 1; k <= 6; k++) begin
      for (int b = 0; b < NB; b++) set_cat(b, (b * k + k) % 7);
      set_cat(0, 0);
      run_scan(1 + (k % 3), 0, $sformatf("sweep%0d", k));
      verify($sformatf("sweep%0d", k));
    end

    // R5 error with FFh data on page 0, same response
    for (int b = 0; b < NB; b++) set_cat(b, (b % 2 == 1) ? 5 : 0);
    run_scan(2, 0, "err-ff");
    verify("err-ff R5");

    // R7 exactly MAX_BAD bad, last block included
    for (int b = 0; b < NB; b++) set_cat(b, 0);
    set_cat(1, 1); set_cat(7, 2); set_cat(NB - 1, 1);
    run_scan(1, 0, "at-limit");
    verify("at-limit R7");
    chk(anomaly == 1'b0, "R7 no anomaly at limit", int'(anomaly), 0);

    // R7 one above MAX_BAD
    set_cat(4, 4);
    run_scan(1, 0, "over-limit");
    verify("over-limit R7");
    chk(anomaly == 1'b1, "R7 anomaly over limit", int'(anomaly), 1);

    // R7 block 0 bad alone
    for (int b = 0; b < NB; b++) set_cat(b, 0);
    set_cat(0, 2);
    run_scan(3, 0, "blk0");
    verify("blk0 R7");
    chk(bad_count == KW'(1) && anomaly, "R7 block0 anomaly", int'(anomaly), 1);

    // R8 start during scan ignored
    for (int b = 0; b < NB; b++) set_cat(b, (b % 3 == 2) ? 1 : 0);
    run_scan(2, 1, "mid-start");
    verify("mid-start R8");

    // R1 restart clears previous results
    for (int b = 0; b < NB; b++) set_cat(b, 0);
    run_scan(1, 0, "restart");
    verify("restart R1");

    summary();
    $finish;
  end

endmodule